// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block owns one 8-bit general purpose port on a 32-bit register bus. Software sets the value each pin drives and whether its driver is on. It reads the pin levels after a two-flop synchronizer. Each pin also has a 3-bit trigger mode. The mode can leave the pin silent, track a high or low level, force a request, or catch rising, falling or both edges.

Requests collect in a raw pending register. A mask register selects which pending bits count, and an acknowledge register clears latched edge requests when software writes ones to it. The masked pending bits are ORed into a single registered interrupt line. The bus takes a byte offset. A write happens in the cycle where `bus_wr` is high. Read data is combinational from `bus_addr`.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset the output data, output enable, trigger mode and mask registers read zero, and `irq` is low.
- R2: A write to offset 0 sets the pin drive values and a write to offset 8 sets the driver enables. Both read back at their offsets and appear on `pin_out` and `pin_oe` one cycle after the write.
- R3: Offset 4 reads the pin levels through a two-flop synchronizer, so a pin change shows there two clock edges after it is applied.
- R4: Offset 12 holds the trigger modes, with pin i in bits [3i+2:3i]. Mode 1 (level high) and mode 2 (level low) make the pending bit follow the synchronized pin while the level condition holds, so an acknowledge has no lasting effect on them.
- R5: Mode 3 keeps the pin's pending bit set for as long as the mode is selected.
- R6: Mode 5 (rising), mode 6 (falling) and mode 7 (either edge) set the pending bit one edge after the synchronized value changes. The bit stays set after the pin settles.
- R7: Writing 1 to a bit at offset 20 clears that pin's latched edge request, and writing 0 leaves it unchanged. Offset 20 always reads zero.
- R8: When a new edge is detected in the same cycle as the acknowledge of that pin, the pending bit stays set.
- R9: Modes 0 and 4 never set a pending bit.
- R10: Offset 24 reads the raw pending bits and offset 28 reads raw AND mask, where the mask sits at offset 16. Bits [31:8] of these views read zero.
- R11: `irq` is a register that equals the OR of the masked pending bits of the previous cycle.
- R12: Writes to any other offset change nothing, and reads from any other offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 7 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pin_in | input | 8 | Pin levels from the pads |
| pin_out | output | 8 | Pin drive values |
| pin_oe | output | 8 | Pin driver enables |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `pin_in` is asynchronous and that the bus offset stays stable for the whole cycle. They also assume that mode codes come only from the 3-bit fields. The bench changes pins and bus signals only on the falling clock edge. It holds an acknowledge write for exactly one cycle, and it lines up the acknowledge of one pin with the edge that the synchronizer delivers on that cycle. This exercises the collision case without breaking the single-write assumption.

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int W  = 8,
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pin_oe,
  output logic          irq
);
  localparam int CW = 3 * W;
  localparam logic [AW-1:0] A_DOUT = AW'(0);
  localparam logic [AW-1:0] A_DIN  = AW'(4);
  localparam logic [AW-1:0] A_OE   = AW'(8);
  localparam logic [AW-1:0] A_CFG  = AW'(12);
  localparam logic [AW-1:0] A_MASK = AW'(16);
  localparam logic [AW-1:0] A_ACK  = AW'(20);
  localparam logic [AW-1:0] A_RAW  = AW'(24);
  localparam logic [AW-1:0] A_MSK  = AW'(28);

  logic [W-1:0]  dout_q, oe_q, mask_q, raw_q, raw_d;
  logic [CW-1:0] cfg_q;
  logic [W-1:0]  sync1_q, sync2_q, prev_q;
  logic [W-1:0]  ack_hit, masked;

  assign ack_hit = (bus_wr && bus_addr == A_ACK) ? bus_wdata[W-1:0] : '0;
  assign masked  = raw_q & mask_q;
  assign pin_out = dout_q;
  assign pin_oe  = oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      oe_q   <= '0;
      cfg_q  <= '0;
      mask_q <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_DOUT:  dout_q <= bus_wdata[W-1:0];
        A_OE:    oe_q   <= bus_wdata[W-1:0];
        A_CFG:   cfg_q  <= bus_wdata[CW-1:0];
        A_MASK:  mask_q <= bus_wdata[W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
      raw_q   <= '0;
      irq     <= 1'b0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      raw_q   <= raw_d;
      irq     <= |masked;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic rise, fall, keep;
    assign rise = sync2_q[i] & ~prev_q[i];
    assign fall = ~sync2_q[i] & prev_q[i];
    assign keep = raw_q[i] & ~ack_hit[i];
    always_comb begin
      case (cfg_q[3*i +: 3])
        3'd1:    raw_d[i] = sync2_q[i];
        3'd2:    raw_d[i] = ~sync2_q[i];
        3'd3:    raw_d[i] = 1'b1;
        3'd5:    raw_d[i] = rise | keep;
        3'd6:    raw_d[i] = fall | keep;
        3'd7:    raw_d[i] = rise | fall | keep;
        default: raw_d[i] = 1'b0;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_DOUT:  bus_rdata[W-1:0]  = dout_q;
      A_DIN:   bus_rdata[W-1:0]  = sync2_q;
      A_OE:    bus_rdata[W-1:0]  = oe_q;
      A_CFG:   bus_rdata[CW-1:0] = cfg_q;
      A_MASK:  bus_rdata[W-1:0]  = mask_q;
      A_RAW:   bus_rdata[W-1:0]  = raw_q;
      A_MSK:   bus_rdata[W-1:0]  = masked;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
  parameter int W  = 8,
  parameter int AW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic [31:0]   bus_rdata,
  input logic [3*W-1:0] cfg,
  input logic [W-1:0]  raw,
  input logic [W-1:0]  mask,
  input logic          irq
);
  assert_irq_delay_R11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq == $past(|(raw & mask)));

  assert_ack_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == AW'(20) |-> bus_rdata == 32'd0);

  assert_status_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AW'(24) || bus_addr == AW'(28)) |-> bus_rdata[31:W] == '0);

  for (genvar i = 0; i < W; i++) begin : g_chk
    assert_set_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cfg[3*i +: 3] == 3'd3 |=> raw[i]);
    assert_off_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg[3*i +: 3] == 3'd0 || cfg[3*i +: 3] == 3'd4) |=> !raw[i]);
  end
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.W(W), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .cfg(cfg_q), .raw(raw_q), .mask(mask_q), .irq(irq)
);

// File: tb/gpio_irq_ctrl_tb_top.sv
module gpio_irq_ctrl_tb_top;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  pin_in = '0;
  logic [7:0]  pin_out, pin_oe;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  gpio_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // behavioural reference
  logic [7:0]  m_dout, m_oe, m_mask, m_raw, m_s1, m_s2, m_prev;
  logic [23:0] m_cfg;
  logic        m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dout = 0; m_oe = 0; m_mask = 0; m_raw = 0; m_cfg = 0;
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_irq = 0;
    end else begin
      logic [7:0] nraw;
      m_irq = |(m_raw & m_mask);
      for (int i = 0; i < 8; i++) begin
        int md;
        bit up, dn, hold;
        md = int'((m_cfg >> (3*i)) & 24'd7);
        up = m_s2[i] && !m_prev[i];
        dn = !m_s2[i] && m_prev[i];
        hold = m_raw[i] && !(bus_wr && bus_addr == 20 && bus_wdata[i]);
        case (md)
          1: nraw[i] = m_s2[i];
          2: nraw[i] = !m_s2[i];
          3: nraw[i] = 1'b1;
          5: nraw[i] = up || hold;
          6: nraw[i] = dn || hold;
          7: nraw[i] = up || dn || hold;
          default: nraw[i] = 1'b0;
        endcase
      end
      m_raw = nraw;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
      if (bus_wr) begin
        if (bus_addr == 0)  m_dout = bus_wdata[7:0];
        if (bus_addr == 8)  m_oe   = bus_wdata[7:0];
        if (bus_addr == 12) m_cfg  = bus_wdata[23:0];
        if (bus_addr == 16) m_mask = bus_wdata[7:0];
      end
    end
  end

  function automatic logic [31:0] m_read(input logic [6:0] a);
    case (a)
      0:  return {24'd0, m_dout};
      4:  return {24'd0, m_s2};
      8:  return {24'd0, m_oe};
      12: return {8'd0, m_cfg};
      16: return {24'd0, m_mask};
      24: return {24'd0, m_raw};
      28: return {24'd0, m_raw & m_mask};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n && !done) begin
    check("R2 pin_out", {24'd0, pin_out}, {24'd0, m_dout});
    check("R2 pin_oe", {24'd0, pin_oe}, {24'd0, m_oe});
    check("R11 irq", {31'd0, irq}, {31'd0, m_irq});
    check("R10 rdata", bus_rdata, m_read(bus_addr));
  end

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [6:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(PERIOD*200000);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(2);
    rst_n = 1'b1;
    @(negedge clk);
    rd("R1 dout", 0, 0); rd("R1 oe", 8, 0); rd("R1 cfg", 12, 0); rd("R1 mask", 16, 0);
    check("R1 irq", {31'd0, irq}, 0);

    wr(0, 32'hA5); wr(8, 32'h0F);
    rd("R2 dout", 0, 32'hA5); rd("R2 oe", 8, 32'h0F);
    check("R2 pin_out", {24'd0, pin_out}, 32'hA5);

    pin_in = 8'h3C; idle(3);
    rd("R3 din", 4, 32'h3C);
    pin_in = 8'h00; idle(3);

    wr(32, 32'hFFFF_FFFF); wr(44, 32'hFFFF_FFFF);
    rd("R12 read", 32, 0); rd("R12 dout kept", 0, 32'hA5);
    rd("R12 mask kept", 16, 0); rd("R12 cfg kept", 12, 0);

    wr(12, 32'd1 | (32'd2 << 3) | (32'd3 << 6) | (32'd5 << 9) |
           (32'd6 << 12) | (32'd7 << 15) | (32'd4 << 18));
    idle(2);
    rd("R4 R5 raw", 24, 32'h06);
    rd("R10 masked none", 28, 0);
    wr(16, 32'hFF); idle(2);
    rd("R10 masked", 28, 32'h06);
    check("R11 irq high", {31'd0, irq}, 1);

    pin_in = 8'hFF; idle(4);
    rd("R6 R9 rise", 24, 32'h2D);
    pin_in = 8'h00; idle(4);
    rd("R6 sticky fall", 24, 32'h3E);

    wr(20, 32'h00); idle(1);
    rd("R7 ack zero", 24, 32'h3E);
    wr(20, 32'hFF); idle(1);
    rd("R7 R4 ack", 24, 32'h06);
    rd("R7 ack reads", 20, 0);

    pin_in = 8'h08;
    @(posedge clk); @(posedge clk); @(negedge clk);
    wr(20, 32'h08); idle(1);
    rd("R8 edge wins", 24, 32'h0E);

    wr(16, 32'h08); idle(2);
    rd("R10 partial", 28, 32'h08);
    check("R11 irq on", {31'd0, irq}, 1);
    wr(20, 32'h08);
    rd("R11 masked cleared", 28, 0);
    @(negedge clk);
    check("R11 irq off", {31'd0, irq}, 0);
    idle(3);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule